// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block holds one 8-bit interrupt flag word for a small microcontroller-style peripheral bus. The word gathers events from six sources: a synchronous serial port (bus collision and general event), two UART channels (receive data waiting and transmit buffer empty), and two logic-cell event sources. Four of the bits are sticky. A single-cycle pulse from hardware sets such a bit, and it stays set until software writes it. The other four bits are read-only live copies of the UART buffer levels. They change only through the UART data registers: reading the receive data register empties the receive buffer, and loading the transmit data register fills the transmit buffer.

Software reaches the block through a simple register port. The port has an address, a read strobe, a write strobe and write data, and read data comes back combinationally in the same cycle. The block also decodes the four UART data register addresses. For these it sends one-cycle strobes to the UART models, so the side effects happen in the UART and the live flags follow. A second register at its own address holds per-bit enables with the same bit layout. The interrupt request output is the OR of all enabled flags, gated by a global enable input.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, the flag word reads 0x00 when all live inputs are low, the enable word reads 0x00, and the interrupt request is low.
- R2: The flag word is at address 0x08F and the enable word is at address 0x090. The bit layout of both words is: bit 7 serial-port collision, bit 6 serial-port event, bit 5 UART2 receive, bit 4 UART2 transmit, bit 3 UART1 receive, bit 2 UART1 transmit, bit 1 logic-cell 4, bit 0 logic-cell 3.
- R3: A one-cycle pulse on a sticky source input (bits 7, 6, 1, 0) sets that flag at the next clock edge. The flag stays set after the pulse ends.
- R4: A write to the flag address loads bits 7, 6, 1 and 0 from the write data at the next edge. Writing 0 clears a sticky flag and writing 1 sets it.
- R5: If a set pulse and a software write of 0 reach the same sticky bit in the same cycle, the bit ends up set.
- R6: Bits 5 to 2 of the flag word always show the live UART inputs. A write to the flag address has no effect on them.
- R7: A receive flag reads 1 while that channel's receive-not-empty input is high. A read of receive data address 0x099 (UART1) or 0x09B (UART2) raises that channel's pop strobe for exactly that cycle.
- R8: A transmit flag reads 1 while that channel's transmit-empty input is high. A write to transmit data address 0x09A (UART1) or 0x09C (UART2) raises that channel's load strobe for exactly that cycle.
- R9: Flags set and show their state whatever the values of the enable word and the global enable.
- R10: The interrupt request is high, in the same cycle, exactly when the global enable is high and at least one flag bit has its matching enable bit set.
- R11: Read data is valid in the cycle of the read strobe. It is 0x00 when no read is active or when the read address is not the flag or enable address.
- R12: A write to the enable address stores all eight bits, and they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| ssp_coll_pulse | input | 1 | Serial-port bus collision event |
| ssp_evt_pulse | input | 1 | Serial-port general event |
| cell3_pulse | input | 1 | Logic-cell 3 event |
| cell4_pulse | input | 1 | Logic-cell 4 event |
| u1_rx_nonempty | input | 1 | UART1 receive buffer holds data |
| u1_tx_empty | input | 1 | UART1 transmit buffer empty |
| u2_rx_nonempty | input | 1 | UART2 receive buffer holds data |
| u2_tx_empty | input | 1 | UART2 transmit buffer empty |
| u1_rx_pop | output | 1 | UART1 receive data register read strobe |
| u1_tx_load | output | 1 | UART1 transmit data register write strobe |
| u2_rx_pop | output | 1 | UART2 receive data register read strobe |
| u2_tx_load | output | 1 | UART2 transmit data register write strobe |
| global_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives a write of 0 to the flag word in the same cycle as a set pulse. A design that gives priority to the write would lose that event. It writes all ones and all zeros to the flag word while the UART inputs are held at fixed levels. A design that stored the read-only bits would then show values that differ from the live buffer state. It sets flags with the enables and the global enable off, then checks that the request stays low until both enables allow it. A design that gated the flag itself, or dropped the global gate, fails this check. It also checks that each UART data address raises only its own strobe, and only in the access cycle, because a wrong decode would drain or load the wrong channel.

// File: rtl/irqf_pkg.sv
// Package irqf_pkg
// Shared word type and bit positions for the interrupt flag bank.
// Assumes a fixed 8-bit layout; only addresses are parameters of the top.
package irqf_pkg;

    localparam int FLAG_W   = 8;
    localparam int STICKY_N = 4;

    typedef logic [FLAG_W-1:0] flag_word_t;

    // Bit positions of the live UART status flags
    localparam int POS_U2_RX = 5;
    localparam int POS_U2_TX = 4;
    localparam int POS_U1_RX = 3;
    localparam int POS_U1_TX = 2;

    // Map sticky index (3: collision, 2: serial event, 1: cell 4, 0: cell 3)
    // onto its position in the flag word.
    function automatic int sticky_pos(input int idx);
        case (idx)
            3:       return 7;
            2:       return 6;
            1:       return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/irqf_sticky_bit.sv
// Module irqf_sticky_bit
// One hardware-set, software-written flag bit.
// Assumes set_i is a pulse from the source domain already synchronous to clk.
// A set in the same cycle as a software write always wins.
module irqf_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic q_o
);

    // Flag state: set has priority over a write, a write over hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (wr_i)
            q_o <= wdata_i;
    end

endmodule

// File: rtl/irqf_enable_reg.sv
// Module irqf_enable_reg
// Plain software-written enable word, one bit per flag position.
// Assumes wr_i is already qualified by the address decode.
module irqf_enable_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);

    // Enable storage, loaded whole on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (wr_i)
            q_o <= wdata_i;
    end

endmodule

// File: rtl/irqf_req_combine.sv
// Module irqf_req_combine
// Reduces flags and enables to one interrupt request, gated globally.
// Purely combinational; assumes the consumer registers it if needed.
module irqf_req_combine #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] ena_i,
    input  logic         gie_i,
    output logic         irq_o
);

    logic [W-1:0] masked;

    // Per-bit mask, then OR-reduce and apply the global gate
    always_comb begin
        masked = flags_i & ena_i;
        irq_o  = gie_i & (|masked);
    end

endmodule

// File: rtl/irq_flag_bank.sv
// Module irq_flag_bank
// Interrupt flag word with four sticky bits and four live UART status bits,
// an enable word, same-cycle read data, UART data register side-effect
// strobes and a combined interrupt request.
// Assumes one bus access per cycle and event pulses synchronous to clk.
module irq_flag_bank #(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 12'h08F,
    parameter logic [ADDR_W-1:0] ENA_ADDR  = 12'h090,
    parameter logic [ADDR_W-1:0] RX1_ADDR  = 12'h099,
    parameter logic [ADDR_W-1:0] TX1_ADDR  = 12'h09A,
    parameter logic [ADDR_W-1:0] RX2_ADDR  = 12'h09B,
    parameter logic [ADDR_W-1:0] TX2_ADDR  = 12'h09C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ssp_coll_pulse,
    input  logic              ssp_evt_pulse,
    input  logic              cell3_pulse,
    input  logic              cell4_pulse,
    input  logic              u1_rx_nonempty,
    input  logic              u1_tx_empty,
    input  logic              u2_rx_nonempty,
    input  logic              u2_tx_empty,
    output logic              u1_rx_pop,
    output logic              u1_tx_load,
    output logic              u2_rx_pop,
    output logic              u2_tx_load,
    input  logic              global_en,
    output logic              irq
);
    import irqf_pkg::*;

    localparam int NS = STICKY_N;

    logic [NS-1:0] evt_vec;
    logic [NS-1:0] sticky_q;
    logic          flag_wr;
    logic          ena_wr;
    flag_word_t    flag_word;
    flag_word_t    ena_q;

    // Gather sticky sources in index order (3 collision .. 0 cell 3)
    always_comb begin
        evt_vec = {ssp_coll_pulse, ssp_evt_pulse, cell4_pulse, cell3_pulse};
    end

    // Address decode for register writes
    always_comb begin
        flag_wr = bus_wr && (bus_addr == FLAG_ADDR);
        ena_wr  = bus_wr && (bus_addr == ENA_ADDR);
    end

    // Side-effect strobes for the UART data registers
    always_comb begin
        u1_rx_pop  = bus_rd && (bus_addr == RX1_ADDR);
        u2_rx_pop  = bus_rd && (bus_addr == RX2_ADDR);
        u1_tx_load = bus_wr && (bus_addr == TX1_ADDR);
        u2_tx_load = bus_wr && (bus_addr == TX2_ADDR);
    end

    // One sticky cell per hardware-set flag position
    for (genvar gi = 0; gi < NS; gi++) begin : g_sticky
        irqf_sticky_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (evt_vec[gi]),
            .wr_i    (flag_wr),
            .wdata_i (bus_wdata[sticky_pos(gi)]),
            .q_o     (sticky_q[gi])
        );
    end

    // Assemble the visible flag word from sticky state and live status
    always_comb begin
        flag_word = '0;
        for (int i = 0; i < NS; i++)
            flag_word[sticky_pos(i)] = sticky_q[i];
        flag_word[POS_U2_RX] = u2_rx_nonempty;
        flag_word[POS_U2_TX] = u2_tx_empty;
        flag_word[POS_U1_RX] = u1_rx_nonempty;
        flag_word[POS_U1_TX] = u1_tx_empty;
    end

    irqf_enable_reg #(.W(FLAG_W)) u_ena (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ena_wr),
        .wdata_i (bus_wdata),
        .q_o     (ena_q)
    );

    // Same-cycle read mux; idle or unmapped reads return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && bus_addr == FLAG_ADDR)
            bus_rdata = flag_word;
        else if (bus_rd && bus_addr == ENA_ADDR)
            bus_rdata = ena_q;
    end

    irqf_req_combine #(.W(FLAG_W)) u_req (
        .flags_i (flag_word),
        .ena_i   (ena_q),
        .gie_i   (global_en),
        .irq_o   (irq)
    );

endmodule

// File: rtl/irqf_chk.sv
// Module irqf_chk
// Property checker bound into irq_flag_bank; observes only, drives nothing.
module irqf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] evt_vec,
    input logic [3:0] sticky_q,
    input logic       flag_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       u1_rx_pop,
    input logic       u1_tx_load,
    input logic       u2_rx_pop,
    input logic       u2_tx_load,
    input logic       global_en,
    input logic       irq
);

    // R3
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vec[3] |=> sticky_q[3]);

    // R5
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec[0] && flag_wr) |=> sticky_q[0]);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|evt_vec) && !flag_wr) |=> $stable(sticky_q));

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |-> !irq);

    // R7
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({u1_rx_pop, u1_tx_load, u2_rx_pop, u2_tx_load}));

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));

endmodule

bind irq_flag_bank irqf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_vec    (evt_vec),
    .sticky_q   (sticky_q),
    .flag_wr    (flag_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .u1_rx_pop  (u1_rx_pop),
    .u1_tx_load (u1_tx_load),
    .u2_rx_pop  (u2_rx_pop),
    .u2_tx_load (u2_tx_load),
    .global_en  (global_en),
    .irq        (irq)
);

// File: tb/sim_irq_flag_bank.sv
// Directed bench for irq_flag_bank: inputs change on falling edges,
// outputs are sampled one time unit after a falling edge.
module sim_irq_flag_bank;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_FLAG = 12'h08F;
    localparam logic [11:0] A_ENA  = 12'h090;
    localparam logic [11:0] A_RX1  = 12'h099;
    localparam logic [11:0] A_TX1  = 12'h09A;
    localparam logic [11:0] A_RX2  = 12'h09B;
    localparam logic [11:0] A_TX2  = 12'h09C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ssp_coll_pulse = 0, ssp_evt_pulse = 0, cell3_pulse = 0, cell4_pulse = 0;
    logic        u1_rx_nonempty = 0, u1_tx_empty = 0, u2_rx_nonempty = 0, u2_tx_empty = 0;
    logic        u1_rx_pop, u1_tx_load, u2_rx_pop, u2_tx_load;
    logic        global_en = 0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ssp_coll_pulse(ssp_coll_pulse), .ssp_evt_pulse(ssp_evt_pulse),
        .cell3_pulse(cell3_pulse), .cell4_pulse(cell4_pulse),
        .u1_rx_nonempty(u1_rx_nonempty), .u1_tx_empty(u1_tx_empty),
        .u2_rx_nonempty(u2_rx_nonempty), .u2_tx_empty(u2_tx_empty),
        .u1_rx_pop(u1_rx_pop), .u1_tx_load(u1_tx_load),
        .u2_rx_pop(u2_rx_pop), .u2_tx_load(u2_tx_load),
        .global_en(global_en), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(A_FLAG, v); check("R1 flags", v, 8'h00);
        bus_read(A_ENA, v);  check("R1 enables", v, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        @(negedge clk); ssp_coll_pulse = 1;
        @(negedge clk); ssp_coll_pulse = 0;
        bus_read(A_FLAG, v); check("R3/R2 collision bit7", v, 8'h80);
        @(negedge clk); cell3_pulse = 1;
        @(negedge clk); cell3_pulse = 0;
        repeat (4) @(negedge clk);
        bus_read(A_FLAG, v); check("R3 held bit0", v, 8'h81);
        @(negedge clk); ssp_evt_pulse = 1; cell4_pulse = 1;
        @(negedge clk); ssp_evt_pulse = 0; cell4_pulse = 0;
        bus_read(A_FLAG, v); check("R2 sticky layout", v, 8'hC3);
    endtask

    task automatic t_sw_write();
        logic [7:0] v;
        bus_write(A_FLAG, 8'h00);
        bus_read(A_FLAG, v); check("R4 clear by write", v, 8'h00);
        bus_write(A_FLAG, 8'hFF);
        bus_read(A_FLAG, v); check("R4/R6 write ones", v, 8'hC3);
        bus_write(A_FLAG, 8'h41);
        bus_read(A_FLAG, v); check("R4 partial write", v, 8'h41);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        bus_write(A_FLAG, 8'h00);
        @(negedge clk);
        bus_addr = A_FLAG; bus_wdata = 8'h00; bus_wr = 1; cell4_pulse = 1; ssp_coll_pulse = 1;
        @(negedge clk);
        bus_wr = 0; cell4_pulse = 0; ssp_coll_pulse = 0;
        bus_read(A_FLAG, v); check("R5 set wins", v, 8'h82);
        bus_write(A_FLAG, 8'h00);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        @(negedge clk); u2_rx_nonempty = 1; u1_tx_empty = 1;
        bus_read(A_FLAG, v); check("R6 live bits", v, 8'h24);
        bus_write(A_FLAG, 8'h00);
        bus_read(A_FLAG, v); check("R6 write 0 ignored", v, 8'h24);
        @(negedge clk); u2_rx_nonempty = 0; u1_tx_empty = 0;
        bus_write(A_FLAG, 8'h3C);
        bus_read(A_FLAG, v); check("R6 write 1 ignored", v, 8'h00);
        @(negedge clk); u1_rx_nonempty = 1; u2_tx_empty = 1;
        bus_read(A_FLAG, v); check("R6 other live bits", v, 8'h18);
    endtask

    task automatic t_uart();
        logic [7:0] s;
        // u1 rx buffer holds a byte; reading RX1 pops it
        @(negedge clk); bus_addr = A_RX1; bus_rd = 1;
        #1 s = {4'b0, u1_rx_pop, u2_rx_pop, u1_tx_load, u2_tx_load};
        check("R7 rx1 pop strobe", s, 8'h08);
        @(negedge clk); bus_rd = 0; u1_rx_nonempty = 0;
        #1 check("R7 pop one cycle", {7'b0, u1_rx_pop}, 8'h00);
        bus_read(A_FLAG, s); check("R7 rx1 flag cleared", s, 8'h10);
        @(negedge clk); bus_addr = A_RX2; bus_rd = 1;
        #1 s = {4'b0, u1_rx_pop, u2_rx_pop, u1_tx_load, u2_tx_load};
        check("R7 rx2 pop strobe", s, 8'h04);
        @(negedge clk); bus_rd = 0;
        // write TX2 loads its buffer
        @(negedge clk); bus_addr = A_TX2; bus_wdata = 8'h5A; bus_wr = 1;
        #1 s = {4'b0, u1_rx_pop, u2_rx_pop, u1_tx_load, u2_tx_load};
        check("R8 tx2 load strobe", s, 8'h01);
        @(negedge clk); bus_wr = 0; u2_tx_empty = 0;
        #1 check("R8 load one cycle", {7'b0, u2_tx_load}, 8'h00);
        bus_read(A_FLAG, s); check("R8 tx2 flag cleared", s, 8'h00);
        @(negedge clk); bus_addr = A_TX1; bus_wr = 1;
        #1 s = {4'b0, u1_rx_pop, u2_rx_pop, u1_tx_load, u2_tx_load};
        check("R8 tx1 load strobe", s, 8'h02);
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic t_irq();
        logic [7:0] v;
        @(negedge clk); global_en = 1;
        @(negedge clk); ssp_evt_pulse = 1;
        @(negedge clk); ssp_evt_pulse = 0;
        #1 check("R9 irq off with enables 0", {7'b0, irq}, 8'h00);
        bus_read(A_FLAG, v); check("R9 flag set while disabled", v, 8'h40);
        bus_write(A_ENA, 8'h40);
        bus_read(A_ENA, v); check("R12 enable readback", v, 8'h40);
        #1 check("R10 irq enabled", {7'b0, irq}, 8'h01);
        @(negedge clk); global_en = 0;
        #1 check("R10 global gate", {7'b0, irq}, 8'h00);
        @(negedge clk); global_en = 1;
        bus_write(A_FLAG, 8'h00);
        #1 check("R10 irq after clear", {7'b0, irq}, 8'h00);
        bus_write(A_ENA, 8'hA5);
        bus_read(A_ENA, v); check("R12 pattern", v, 8'hA5);
        #1 check("R10 masked bits off", {7'b0, irq}, 8'h00);
        @(negedge clk); u1_tx_empty = 1;
        #1 check("R10 live bit irq", {7'b0, irq}, 8'h01);
        @(negedge clk); u1_tx_empty = 0;
    endtask

    task automatic t_rdata();
        logic [7:0] v;
        @(negedge clk); u2_rx_nonempty = 1; bus_addr = A_FLAG; bus_rd = 0;
        #1 check("R11 no read gives 0", bus_rdata, 8'h00);
        bus_read(12'h091, v); check("R11 unmapped read", v, 8'h00);
        bus_read(A_FLAG, v); check("R11 same-cycle read", v, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_sticky();
        t_sw_write();
        t_collide();
        t_readonly();
        @(negedge clk); u1_rx_nonempty = 1; u2_tx_empty = 1; u2_rx_nonempty = 0;
        t_uart();
        t_irq();
        t_rdata();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule